// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status Aggregator

This block gathers single-cycle event pulses from an Ethernet DMA engine, plus one combined level from the MAC core layer, into one status word. Each DMA event latches a status bit. The DMA bits fall into two groups: a normal group for routine transfer progress and an abnormal group for error and stall conditions. Each group produces a summary bit, which is the OR of its status bits gated by per-source enables.

A single registered, level-sensitive interrupt line goes to the processor. It is the OR of the two summaries, each gated by its own summary enable, together with the core-layer mirror bit gated by its enable. Any burst of events, whether the events are simultaneous or arrive while the line is already high, produces one assertion. The line stays high until software has cleared every enabled pending bit.

Software reaches the block through a small register port with read, write, address and data signals. Status bits are cleared by writing ones. The core-layer mirror bit is read-only and follows its source.

Top module: `eth_irq_aggregator`

## Requirements
- R1: After reset, the status word, the enable word and `irq` are all zero.
- R2: A pulse on `dma_evt[i]` sets status bit i at the next clock edge, whether or not enable bit i is set. The bit layout is as follows. Normal group: bit 0 transmit done, bit 1 transmit buffer unavailable, bit 2 receive done, bit 3 early receive. Abnormal group: bit 4 transmit stopped, bit 5 jabber timeout, bit 6 receive overflow, bit 7 transmit underflow, bit 8 receive buffer unavailable, bit 9 receive stopped, bit 10 receive watchdog, bit 11 early transmit, bit 12 bus error.
- R3: A write to the status word (address 0x0) clears each source bit whose data bit is 1. Source bits whose data bit is 0 are left unchanged.
- R4: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R5: Status bit 16 (normal summary) reads as the OR of status[3:0] AND enable[3:0]. Status bit 15 (abnormal summary) reads as the OR of status[12:4] AND enable[12:4]. Neither summary depends on the summary enables.
- R6: `irq` is registered and changes one clock after the state change that causes it. It equals (bit 16 AND enable[16]) OR (bit 15 AND enable[15]) OR (bit 27 AND enable[27]).
- R7: Several events in one cycle, or events arriving while `irq` is high, produce exactly one rising edge of `irq`.
- R8: Clearing one enabled pending bit while another enabled bit is still set leaves `irq` high.
- R9: Status bit 27 mirrors `core_evt` with one cycle of delay. Writes to it are ignored, and it clears only when `core_evt` falls.
- R10: The enable word at address 0x4 is read/write on bits 0–12, 15, 16 and 27. Its other bits read as zero. A read of any address other than 0x0 and 0x4 returns zero. Read data appears on `reg_rdata` one clock after `reg_rd` and holds until the next read.
- R11: Once all enabled bits have been cleared and `irq` has dropped, a new enabled event raises `irq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_evt | input | 13 | One-cycle event pulses from the DMA engine, one per status source |
| core_evt | input | 1 | Combined, pre-masked core-layer interrupt level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt line to the processor |

## Verification
The bench fires all thirteen sources in one cycle and then fires more events while the line is high, counting rising edges of `irq`. A design that re-pulsed the line per event would show extra edges. It clears one of two enabled pending bits and checks that the line stays high, which catches a design that drops the line on any clear. It drives an event and a clear into the same bit in the same cycle, where a design with the wrong priority would lose the event. It also writes a clear to the core mirror bit and disables the summary enables while sources are pending, which exposes designs that let software clear the mirror or that skip the second level of gating.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int NUM_SRC      = 13;
  localparam int NORM_LO      = 0;
  localparam int NORM_HI      = 3;
  localparam int ABN_LO       = 4;
  localparam int ABN_HI       = 12;
  localparam int BIT_ABN_SUM  = 15;
  localparam int BIT_NORM_SUM = 16;
  localparam int BIT_CORE     = 27;
  localparam int OFF_STAT     = 0;
  localparam int OFF_EN       = 4;
  localparam int NUM_GRP      = 2;
  localparam int GRP_NORM     = 0;
  localparam int GRP_ABN      = 1;
endpackage

// File: rtl/eirq_src_bank.sv
module eirq_src_bank #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] stat
);
  logic [N-1:0] stat_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr_hit;
    assign clr_hit = clr_we & clr_mask[i];

    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= evt[i] | (stat_q[i] & ~clr_hit);
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> stat_q[i]); // R2
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && clr_hit) |=> stat_q[i]); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (stat_q[i] && clr_hit && !evt[i]) |=> !stat_q[i]); // R3
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (stat_q[i] && !clr_hit) |=> stat_q[i]); // R3
  end

  assign stat = stat_q;
endmodule

// File: rtl/eirq_group_or.sv
module eirq_group_or #(
  parameter int W = 4
) (
  input  logic [W-1:0] stat,
  input  logic [W-1:0] en,
  output logic         hit
);
  assign hit = |(stat & en);
endmodule

// File: rtl/eirq_line.sv
module eirq_line #(
  parameter int G = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [G-1:0] grp_hit,
  input  logic [G-1:0] grp_en,
  input  logic         core_bit,
  input  logic         core_en,
  output logic         irq
);
  logic req;
  logic irq_q;

  assign req = (|(grp_hit & grp_en)) | (core_bit & core_en);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= req;
  end

  assign irq = irq_q;
endmodule

// File: rtl/eth_irq_aggregator.sv
module eth_irq_aggregator
  import eirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  dma_evt,
  input  logic                core_evt,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq
);
  localparam int N = NUM_SRC;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);

  function automatic logic [DATA_W-1:0] en_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < N; k++) m[k] = 1'b1;
    m[BIT_ABN_SUM]  = 1'b1;
    m[BIT_NORM_SUM] = 1'b1;
    m[BIT_CORE]     = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] EN_MASK = en_mask_f();

  logic                wr_stat, wr_en;
  logic [N-1:0]        stat_src;
  logic [DATA_W-1:0]   en_q;
  logic                core_q;
  logic [NUM_GRP-1:0]  grp_hit;
  logic [NUM_GRP-1:0]  grp_en;
  logic [DATA_W-1:0]   stat_word;
  logic [DATA_W-1:0]   rdata_q;

  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_en   = reg_wr && (reg_addr == A_EN);

  eirq_src_bank #(.N(N)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .evt      (dma_evt),
    .clr_we   (wr_stat),
    .clr_mask (reg_wdata[N-1:0]),
    .stat     (stat_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      core_q <= 1'b0;
    end else begin
      core_q <= core_evt;
      if (wr_en) en_q <= reg_wdata & EN_MASK;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LO = (g == GRP_NORM) ? NORM_LO : ABN_LO;
    localparam int HI = (g == GRP_NORM) ? NORM_HI : ABN_HI;
    eirq_group_or #(.W(HI - LO + 1)) u_or (
      .stat (stat_src[HI:LO]),
      .en   (en_q[HI:LO]),
      .hit  (grp_hit[g])
    );
  end

  assign grp_en[GRP_NORM] = en_q[BIT_NORM_SUM];
  assign grp_en[GRP_ABN]  = en_q[BIT_ABN_SUM];

  eirq_line #(.G(NUM_GRP)) u_line (
    .clk      (clk),
    .rst      (rst),
    .grp_hit  (grp_hit),
    .grp_en   (grp_en),
    .core_bit (core_q),
    .core_en  (en_q[BIT_CORE]),
    .irq      (irq)
  );

  always_comb begin
    stat_word               = '0;
    stat_word[N-1:0]        = stat_src;
    stat_word[BIT_ABN_SUM]  = grp_hit[GRP_ABN];
    stat_word[BIT_NORM_SUM] = grp_hit[GRP_NORM];
    stat_word[BIT_CORE]     = core_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd) begin
      if      (reg_addr == A_STAT) rdata_q <= stat_word;
      else if (reg_addr == A_EN)   rdata_q <= en_q;
      else                         rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;

  AST_NORM_RAISES: assert property (@(posedge clk) disable iff (rst)
    ((|(stat_src[NORM_HI:NORM_LO] & en_q[NORM_HI:NORM_LO])) && en_q[BIT_NORM_SUM]) |=> irq); // R6
  AST_ABN_RAISES: assert property (@(posedge clk) disable iff (rst)
    ((|(stat_src[ABN_HI:ABN_LO] & en_q[ABN_HI:ABN_LO])) && en_q[BIT_ABN_SUM]) |=> irq); // R8
  AST_QUIET_LOW: assert property (@(posedge clk) disable iff (rst)
    (!((|(stat_src[NORM_HI:NORM_LO] & en_q[NORM_HI:NORM_LO])) && en_q[BIT_NORM_SUM]) &&
     !((|(stat_src[ABN_HI:ABN_LO] & en_q[ABN_HI:ABN_LO])) && en_q[BIT_ABN_SUM]) &&
     !(core_q && en_q[BIT_CORE])) |=> !irq); // R11
  AST_CORE_MIRROR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stat_word[BIT_CORE] == $past(core_evt))); // R9
  AST_EN_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~EN_MASK) == '0); // R10
endmodule

// File: tb/test_eth_irq_aggregator.sv
module test_eth_irq_aggregator;
  localparam int CLK_P   = 10;
  localparam int DW      = 32;
  localparam int AW      = 4;
  localparam logic [31:0] ALL_SRC = 32'h0000_1FFF;
  localparam logic [31:0] EN_ALL  = 32'h0801_9FFF;
  localparam logic [31:0] NSUM    = 32'h0001_0000;
  localparam logic [31:0] ASUM    = 32'h0000_8000;
  localparam logic [31:0] CBIT    = 32'h0800_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [12:0]   dma_evt = '0;
  logic          core_evt = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  int rises = 0;
  logic irq_prev = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  eth_irq_aggregator #(.DATA_W(DW), .ADDR_W(AW)) i_eth_irq_aggregator (
    .clk(clk), .rst(rst), .dma_evt(dma_evt), .core_evt(core_evt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst && irq && !irq_prev) rises <= rises + 1;
    irq_prev <= irq;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse(input logic [12:0] m);
    @(negedge clk); dma_evt = m;
    @(negedge clk); dma_evt = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); check(v == 0, "R1 status after reset", v, 0);
    rd(4'h4, v); check(v == 0, "R1 enable after reset", v, 0);
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
  endtask

  task automatic t_set_and_clear();
    logic [31:0] v;
    pulse(13'h0004); cyc(2);
    rd(4'h0, v); check(v == 32'h4, "R2 set without enable", v, 32'h4);
    check(irq == 1'b0, "R2 no irq when disabled", 32'(irq), 0);
    pulse(13'h0020);
    wr(4'h0, 32'h0);
    rd(4'h0, v); check(v == 32'h24, "R3 zero write keeps bits", v, 32'h24);
    wr(4'h0, 32'h4);
    rd(4'h0, v); check(v == 32'h20, "R3 one clears only its bit", v, 32'h20);
    wr(4'h0, ALL_SRC);
    rd(4'h0, v); check(v == 0, "R3 clear all", v, 0);
  endtask

  task automatic t_enable_reg();
    logic [31:0] v;
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); check(v == EN_ALL, "R10 enable readback mask", v, EN_ALL);
    rd(4'h8, v); check(v == 0, "R10 unmapped address reads zero", v, 0);
  endtask

  task automatic t_summary_latency();
    logic [31:0] v;
    wr(4'h4, EN_ALL);
    pulse(13'h0002);
    check(irq == 1'b0, "R6 irq not yet high", 32'(irq), 0);
    @(posedge clk); #1;
    check(irq == 1'b1, "R6 irq one clock later", 32'(irq), 1);
    rd(4'h0, v); check(v == (32'h2 | NSUM), "R5 normal summary", v, 32'h2 | NSUM);
    pulse(13'h0100);
    rd(4'h0, v); check(v == (32'h102 | NSUM | ASUM), "R5 both summaries", v, 32'h102 | NSUM | ASUM);
    wr(4'h0, ALL_SRC); cyc(1);
    check(irq == 1'b0, "R6 irq drops after clear", 32'(irq), 0);
    wr(4'h4, ALL_SRC);
    pulse(13'h0001); cyc(2);
    check(irq == 1'b0, "R6 summary enable gates irq", 32'(irq), 0);
    rd(4'h0, v); check(v == (32'h1 | NSUM), "R5 summary shown ungated", v, 32'h1 | NSUM);
    wr(4'h0, ALL_SRC);
    wr(4'h4, EN_ALL); cyc(2);
  endtask

  task automatic t_once();
    int r0;
    r0 = rises;
    pulse(13'h1FFF); cyc(2);
    pulse(13'h0001); pulse(13'h0200); cyc(3);
    check(rises - r0 == 1, "R7 one rising edge for burst", 32'(rises - r0), 1);
    check(irq == 1'b1, "R7 irq held", 32'(irq), 1);
    wr(4'h0, ALL_SRC); cyc(2);
  endtask

  task automatic t_partial_clear();
    int r0;
    pulse(13'h0104); cyc(2);
    wr(4'h0, 32'h4); cyc(3);
    check(irq == 1'b1, "R8 irq stays with other bit pending", 32'(irq), 1);
    wr(4'h0, 32'h100); cyc(2);
    check(irq == 1'b0, "R8 irq drops when last cleared", 32'(irq), 0);
    r0 = rises;
    pulse(13'h0008); cyc(3);
    check(irq == 1'b1 && rises - r0 == 1, "R11 rearm after clear", 32'(rises - r0), 1);
    wr(4'h0, ALL_SRC); cyc(2);
  endtask

  task automatic t_race();
    logic [31:0] v;
    pulse(13'h0008);
    @(negedge clk);
    dma_evt = 13'h0008; reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h8;
    @(negedge clk);
    dma_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(4'h0, v); check(v == (32'h8 | NSUM), "R4 event beats clear", v, 32'h8 | NSUM);
    wr(4'h0, ALL_SRC); cyc(2);
  endtask

  task automatic t_core();
    logic [31:0] v;
    wr(4'h4, CBIT);
    @(negedge clk); core_evt = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R9 irq after mirror delay", 32'(irq), 0);
    @(posedge clk); #1;
    check(irq == 1'b1, "R9 core raises irq", 32'(irq), 1);
    wr(4'h0, CBIT);
    rd(4'h0, v); check(v == CBIT, "R9 mirror ignores write", v, CBIT);
    @(negedge clk); core_evt = 1'b0; cyc(3);
    rd(4'h0, v); check(v == 0, "R9 mirror follows source", v, 0);
    check(irq == 1'b0, "R9 irq drops with source", 32'(irq), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_set_and_clear();
    t_enable_reg();
    t_summary_latency();
    t_once();
    t_partial_clear();
    t_race();
    t_core();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule